// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register file of a parallel ATA bus that carries two devices. A host writes 8-bit values at a 3-bit register offset and reads them back, writes a separate device-control port, and watches an alternate-status output. Each device keeps its own copy of the task file. Because both devices sit on one bus, every write lands in both copies. The device/head register picks which copy answers reads and which device receives commands.

Writes to the features, sector count and the three LBA registers push the previous value into a high-order shadow. A high-order select bit in device control chooses whether reads of count and LBA return the shadow or the current value. A command write produces a one-cycle strobe for an external command engine and drops the interrupt line. A falling software-reset bit marks both devices busy and, after a fixed delay, reloads the reset signature.

Top module: `ata_taskfile_regs`

## Requirements
- R1: Every task-file write at offsets 1 to 6 updates the copies of both devices, so either device reads back the same count, LBA and device/head values.
- R2: A write to offset 1 (features), 2 (count), 3 (LBA low), 4 (LBA mid) or 5 (LBA high) moves the old value of that register into its shadow before storing the new one.
- R3: While the high-order select control bit is 1, reads at offsets 2 to 5 return the shadow. While it is 0, they return the current value.
- R4: A write at offset 1, 6 or 7 clears the high-order select bit, unless a control write in the same cycle sets it. Writes at offsets 2 to 5 leave the bit unchanged.
- R5: A write at offset 6 stores the value ORed with 0xA0. Bit 4 of the stored value selects device 1 (1) or device 0 (0), and offsets 1 to 7 and the alternate status then read from that device.
- R6: A write at offset 7 raises `cmd_strobe` for exactly one cycle on the next clock. It carries the code, the selected device and {feature shadow, feature}, and the interrupt line is 0 on that same clock.
- R7: `irq_raise` sets the interrupt line on the next clock only when the interrupt-mask control bit is 0. While the mask is 1, a raise has no effect.
- R8: A control write that takes the soft-reset bit from 1 to 0 sets status bit 7 (busy) in both devices on that clock. `SRST_DELAY` clocks later each device reloads the signature: count 0x01, LBA low 0x01, LBA mid and high 0x00, shadows 0x00, device/head 0xA0, status 0x50 (0x00 for a packet device).
- R9: Writing the soft-reset bit from 0 to 1, or writing it as 1 while it is already 1, does not start a reset and does not set busy.
- R10: A read strobe at offset 7 returns the status and clears the interrupt line on the next clock. `alt_status` shows the same value and never affects the interrupt.
- R11: When the selected device is absent, every offset reads 0x00 and `alt_status` is 0x00. For a present device, offset 0 (data) reads 0xFF.
- R12: After hardware reset the task file holds the R8 signature, error (offset 1) reads 0x01, device 0 is selected, all control bits are 0, and the interrupt line and the command strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tf_wr_en | input | 1 | Task-file write strobe |
| tf_wr_addr | input | 3 | Register offset of the write |
| tf_wr_data | input | 8 | Write data |
| tf_rd_en | input | 1 | Read strobe (side effect only at offset 7) |
| tf_rd_addr | input | 3 | Register offset of the read |
| tf_rd_data | output | 8 | Read data, combinational from `tf_rd_addr` |
| ctl_wr_en | input | 1 | Device-control write strobe |
| ctl_wr_hob | input | 1 | New value of the high-order select bit |
| ctl_wr_srst | input | 1 | New value of the soft-reset bit |
| ctl_wr_nien | input | 1 | New value of the interrupt-mask bit |
| alt_status | output | 8 | Status of the selected device, with no side effect |
| irq_raise | input | 1 | Request to raise the interrupt line |
| irq | output | 1 | Interrupt line |
| cmd_strobe | output | 1 | One-cycle command issue pulse |
| cmd_code | output | 8 | Command code issued |
| cmd_dev | output | 1 | Device the command is aimed at |
| cmd_feature | output | 16 | {feature shadow, feature} of the selected device at issue |

## Verification
The embedded properties check on every cycle that both device copies agree, that the device/head register keeps bits 7 and 5 set, and that a shadow takes the previous value on a write. They also check that busy follows a soft-reset edge, that a masked raise leaves the line low, that alternate status equals a status read, and that a command write yields the strobe for the selected device. Only the bench scenarios can show the values read back through the shadow select and the exact cycle at which the signature returns after the reset delay. The same holds for the packet/disk difference in status, the absent-device responses, and the fact that a rising or repeated soft-reset bit does nothing.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   localparam int REG_AW = 3;
   localparam int REG_DW = 8;

   // offsets decoded by the host side; order is part of the bus protocol
   localparam logic [REG_AW-1:0] OFF_DATA   = 3'd0;
   localparam logic [REG_AW-1:0] OFF_FEAT   = 3'd1;
   localparam logic [REG_AW-1:0] OFF_COUNT  = 3'd2;
   localparam logic [REG_AW-1:0] OFF_LBAL   = 3'd3;
   localparam logic [REG_AW-1:0] OFF_LBAM   = 3'd4;
   localparam logic [REG_AW-1:0] OFF_LBAH   = 3'd5;
   localparam logic [REG_AW-1:0] OFF_DEVSEL = 3'd6;
   localparam logic [REG_AW-1:0] OFF_CMD    = 3'd7;

   localparam logic [REG_DW-1:0] DH_FORCE     = 8'hA0;
   localparam int                DH_UNIT_BIT  = 4;
   localparam logic [REG_DW-1:0] ST_BSY       = 8'h80;
   localparam logic [REG_DW-1:0] ST_IDLE_DISK = 8'h50;
   localparam logic [REG_DW-1:0] ST_IDLE_PKT  = 8'h00;
   localparam logic [REG_DW-1:0] ERR_DIAG_OK  = 8'h01;
   localparam logic [REG_DW-1:0] RD_FLOAT     = 8'hFF;
   localparam logic [REG_DW-1:0] RD_ABSENT    = 8'h00;

   // one device's view of the task file
   typedef struct packed {
      logic [REG_DW-1:0] feat;
      logic [REG_DW-1:0] feat_hob;
      logic [REG_DW-1:0] count;
      logic [REG_DW-1:0] count_hob;
      logic [REG_DW-1:0] lbal;
      logic [REG_DW-1:0] lbal_hob;
      logic [REG_DW-1:0] lbam;
      logic [REG_DW-1:0] lbam_hob;
      logic [REG_DW-1:0] lbah;
      logic [REG_DW-1:0] lbah_hob;
      logic [REG_DW-1:0] devsel;
   } tf_file_t;

   // signature value of a shadowed lane: count and LBA low come back as 1
   function automatic logic [REG_DW-1:0] lane_signature(input int lane);
      return (lane == 1 || lane == 2) ? 8'h01 : 8'h00;
   endfunction

endpackage

// File: rtl/ata_tf_bank.sv
module ata_tf_bank
   import ata_tf_pkg::*;
#(
   parameter bit IS_PACKET = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_off,
   input  logic [REG_DW-1:0] wr_data,
   input  logic              busy_set,
   input  logic              sig_load,
   output tf_file_t          file_o,
   output logic [REG_DW-1:0] status_o
);

   localparam int NUM_LANES = 5;

   logic [REG_DW-1:0] lane_cur [NUM_LANES];
   logic [REG_DW-1:0] lane_hob [NUM_LANES];
   logic [REG_DW-1:0] idle_status;
   logic [REG_DW-1:0] devsel_q;
   logic [REG_DW-1:0] status_q;

   if (IS_PACKET) begin : g_packet
      assign idle_status = ST_IDLE_PKT;
   end else begin : g_disk
      assign idle_status = ST_IDLE_DISK;
   end

   // lanes 0..4 map to offsets 1..5; each keeps a value and its shadow
   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam logic [REG_AW-1:0] LANE_OFF = REG_AW'(i + 1);
      localparam logic [REG_DW-1:0] LANE_SIG = lane_signature(i);
      logic [REG_DW-1:0] cur_q;
      logic [REG_DW-1:0] hob_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur_q <= LANE_SIG;
            hob_q <= '0;
         end else if (sig_load) begin
            cur_q <= LANE_SIG;
            hob_q <= '0;
         end else if (wr_en && wr_off == LANE_OFF) begin
            hob_q <= cur_q;
            cur_q <= wr_data;
         end
      end

      assign lane_cur[i] = cur_q;
      assign lane_hob[i] = hob_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         devsel_q <= DH_FORCE;
      end else if (sig_load) begin
         devsel_q <= DH_FORCE;
      end else if (wr_en && wr_off == OFF_DEVSEL) begin
         devsel_q <= wr_data | DH_FORCE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= idle_status;
      end else if (sig_load) begin
         status_q <= busy_set ? (idle_status | ST_BSY) : idle_status;
      end else if (busy_set) begin
         status_q <= status_q | ST_BSY;
      end
   end

   always_comb begin
      file_o.feat      = lane_cur[0];
      file_o.feat_hob  = lane_hob[0];
      file_o.count     = lane_cur[1];
      file_o.count_hob = lane_hob[1];
      file_o.lbal      = lane_cur[2];
      file_o.lbal_hob  = lane_hob[2];
      file_o.lbam      = lane_cur[3];
      file_o.lbam_hob  = lane_hob[3];
      file_o.lbah      = lane_cur[4];
      file_o.lbah_hob  = lane_hob[4];
      file_o.devsel    = devsel_q;
   end
   assign status_o = status_q;

   AST_BSY_ON_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      busy_set |=> status_o[7]); // R8

   AST_SIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_load && !busy_set) |=> (file_o.count == 8'h01 && file_o.lbal == 8'h01 &&
                                   file_o.count_hob == 8'h00 && file_o.devsel == DH_FORCE)); // R8

   AST_SHADOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == OFF_COUNT && !sig_load) |=> file_o.count_hob == $past(file_o.count)); // R2

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl #(
   parameter int SRST_DELAY = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr_en,
   input  logic ctl_wr_hob,
   input  logic ctl_wr_srst,
   input  logic ctl_wr_nien,
   input  logic hob_clr,
   output logic hob_o,
   output logic nien_o,
   output logic srst_fall,
   output logic srst_done
);

   localparam int CNT_W = $clog2(SRST_DELAY + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_DELAY);

   if (SRST_DELAY < 1) begin : g_bad_delay
      $error("SRST_DELAY must be at least 1");
   end

   logic             hob_q;
   logic             srst_q;
   logic             nien_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hob_q  <= 1'b0;
         srst_q <= 1'b0;
         nien_q <= 1'b0;
      end else if (ctl_wr_en) begin
         hob_q  <= ctl_wr_hob;
         srst_q <= ctl_wr_srst;
         nien_q <= ctl_wr_nien;
      end else if (hob_clr) begin
         hob_q  <= 1'b0;
      end
   end

   // reset sequence fires only on a 1 -> 0 transition of the reset bit
   assign srst_fall = ctl_wr_en && srst_q && !ctl_wr_srst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (srst_fall) begin
         cnt_q <= CNT_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign srst_done = (cnt_q == CNT_W'(1));
   assign hob_o     = hob_q;
   assign nien_o    = nien_q;

   AST_HOB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (hob_clr && !ctl_wr_en) |=> !hob_o); // R4

   AST_NO_RESET_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !(ctl_wr_en && srst_q && !ctl_wr_srst)) |=> !srst_done); // R9

endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic mask,
   input  logic drop,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (drop) begin
         irq_q <= 1'b0;
      end else if (raise && !mask) begin
         irq_q <= 1'b1;
      end
   end

   assign irq_o = irq_q;

   AST_MASKED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && !irq_o) |=> !irq_o); // R7

   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !irq_o); // R10

endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
   import ata_tf_pkg::*;
#(
   parameter int         NUM_DEV     = 2,
   parameter logic [1:0] DEV_PRESENT = 2'b11,
   parameter logic [1:0] DEV_PACKET  = 2'b00,
   parameter int         SRST_DELAY  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tf_wr_en,
   input  logic [REG_AW-1:0] tf_wr_addr,
   input  logic [REG_DW-1:0] tf_wr_data,
   input  logic              tf_rd_en,
   input  logic [REG_AW-1:0] tf_rd_addr,
   output logic [REG_DW-1:0] tf_rd_data,
   input  logic              ctl_wr_en,
   input  logic              ctl_wr_hob,
   input  logic              ctl_wr_srst,
   input  logic              ctl_wr_nien,
   output logic [REG_DW-1:0] alt_status,
   input  logic              irq_raise,
   output logic              irq,
   output logic              cmd_strobe,
   output logic [REG_DW-1:0] cmd_code,
   output logic              cmd_dev,
   output logic [2*REG_DW-1:0] cmd_feature
);

   if (NUM_DEV != 2) begin : g_bad_num
      $error("a shared ATA bus carries exactly two devices");
   end

   tf_file_t          file_q   [NUM_DEV];
   logic [REG_DW-1:0] status_q [NUM_DEV];
   tf_file_t          sel_file;
   logic [REG_DW-1:0] sel_status;
   logic              unit;
   logic              sel_present;
   logic              hob_sel;
   logic              nien;
   logic              hob_clr;
   logic              srst_fall;
   logic              srst_done;
   logic              cmd_wr;
   logic              irq_drop;
   logic [REG_DW-1:0] rd_mux;

   // both copies receive every write and every reset event
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      ata_tf_bank #(.IS_PACKET(DEV_PACKET[d])) bank_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (tf_wr_en),
         .wr_off   (tf_wr_addr),
         .wr_data  (tf_wr_data),
         .busy_set (srst_fall),
         .sig_load (srst_done),
         .file_o   (file_q[d]),
         .status_o (status_q[d])
      );
   end

   assign hob_clr = tf_wr_en && (tf_wr_addr == OFF_FEAT || tf_wr_addr == OFF_DEVSEL ||
                                 tf_wr_addr == OFF_CMD);
   assign cmd_wr  = tf_wr_en && tf_wr_addr == OFF_CMD;

   ata_tf_ctrl #(.SRST_DELAY(SRST_DELAY)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr_en   (ctl_wr_en),
      .ctl_wr_hob  (ctl_wr_hob),
      .ctl_wr_srst (ctl_wr_srst),
      .ctl_wr_nien (ctl_wr_nien),
      .hob_clr     (hob_clr),
      .hob_o       (hob_sel),
      .nien_o      (nien),
      .srst_fall   (srst_fall),
      .srst_done   (srst_done)
   );

   assign irq_drop = cmd_wr || (tf_rd_en && tf_rd_addr == OFF_CMD);

   ata_tf_irq irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .raise (irq_raise),
      .mask  (nien),
      .drop  (irq_drop),
      .irq_o (irq)
   );

   assign unit        = file_q[0].devsel[DH_UNIT_BIT];
   assign sel_file    = file_q[unit];
   assign sel_status  = status_q[unit];
   assign sel_present = DEV_PRESENT[unit];

   always_comb begin
      unique case (tf_rd_addr)
         OFF_DATA:   rd_mux = RD_FLOAT;
         OFF_FEAT:   rd_mux = ERR_DIAG_OK;
         OFF_COUNT:  rd_mux = hob_sel ? sel_file.count_hob : sel_file.count;
         OFF_LBAL:   rd_mux = hob_sel ? sel_file.lbal_hob  : sel_file.lbal;
         OFF_LBAM:   rd_mux = hob_sel ? sel_file.lbam_hob  : sel_file.lbam;
         OFF_LBAH:   rd_mux = hob_sel ? sel_file.lbah_hob  : sel_file.lbah;
         OFF_DEVSEL: rd_mux = sel_file.devsel;
         default:    rd_mux = sel_status;
      endcase
   end

   assign tf_rd_data = sel_present ? rd_mux : RD_ABSENT;
   assign alt_status = sel_present ? sel_status : RD_ABSENT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_strobe  <= 1'b0;
         cmd_code    <= '0;
         cmd_dev     <= 1'b0;
         cmd_feature <= '0;
      end else begin
         cmd_strobe <= cmd_wr;
         if (cmd_wr) begin
            cmd_code    <= tf_wr_data;
            cmd_dev     <= unit;
            cmd_feature <= {sel_file.feat_hob, sel_file.feat};
         end
      end
   end

   AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      file_q[0] == file_q[1]); // R1

   AST_DEVSEL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (file_q[0].devsel & DH_FORCE) == DH_FORCE); // R5

   AST_CMD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (cmd_strobe && cmd_dev == $past(unit) && !irq)); // R6

   AST_ALT_EQUALS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (tf_rd_addr == OFF_CMD) |-> alt_status == tf_rd_data); // R10

endmodule

// File: tb/ata_taskfile_regs_tb_top.sv
module ata_taskfile_regs_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;
   localparam int NV         = 27;

   // kind: 0 write, 1 read-check, 2 control write {hob,-,srst,nien at bits 7,2,1}
   typedef struct packed {
      logic [1:0] kind;
      logic [2:0] addr;
      logic [7:0] data;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{2'd0, 3'd2, 8'h11, 8'h00, 4'd2},  // R2 count 11
      '{2'd0, 3'd2, 8'h22, 8'h00, 4'd2},  // R2 count 22, shadow 11
      '{2'd2, 3'd0, 8'h00, 8'h00, 4'd3},
      '{2'd1, 3'd2, 8'h00, 8'h22, 4'd3},  // R3 current
      '{2'd2, 3'd0, 8'h80, 8'h00, 4'd3},
      '{2'd1, 3'd2, 8'h00, 8'h11, 4'd3},  // R3 shadow
      '{2'd1, 3'd3, 8'h00, 8'h00, 4'd3},  // R3 LBA low shadow zero
      '{2'd0, 3'd3, 8'h33, 8'h00, 4'd4},
      '{2'd1, 3'd2, 8'h00, 8'h11, 4'd4},  // R4 LBA write keeps select
      '{2'd0, 3'd3, 8'h44, 8'h00, 4'd2},
      '{2'd1, 3'd3, 8'h00, 8'h33, 4'd2},  // R2 shadow of LBA low
      '{2'd0, 3'd1, 8'h99, 8'h00, 4'd4},
      '{2'd1, 3'd3, 8'h00, 8'h44, 4'd4},  // R4 features write clears select
      '{2'd2, 3'd0, 8'h80, 8'h00, 4'd4},
      '{2'd0, 3'd6, 8'h00, 8'h00, 4'd4},
      '{2'd1, 3'd3, 8'h00, 8'h44, 4'd4},  // R4 device write clears select
      '{2'd1, 3'd6, 8'h00, 8'hA0, 4'd5},  // R5
      '{2'd0, 3'd6, 8'h1F, 8'h00, 4'd5},
      '{2'd1, 3'd6, 8'h00, 8'hBF, 4'd5},  // R5 forced bits
      '{2'd1, 3'd7, 8'h00, 8'h00, 4'd5},  // R5 device 1 is packet
      '{2'd1, 3'd2, 8'h00, 8'h22, 4'd1},  // R1 copy of device 1
      '{2'd1, 3'd3, 8'h00, 8'h44, 4'd1},  // R1
      '{2'd0, 3'd6, 8'h40, 8'h00, 4'd5},
      '{2'd1, 3'd6, 8'h00, 8'hE0, 4'd5},
      '{2'd1, 3'd7, 8'h00, 8'h50, 4'd5},  // R5 device 0 is disk
      '{2'd1, 3'd0, 8'h00, 8'hFF, 4'd11}, // R11 data port
      '{2'd1, 3'd1, 8'h00, 8'h01, 4'd12}  // R12 error
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tf_wr_en = 1'b0;
   logic [2:0]  tf_wr_addr = '0;
   logic [7:0]  tf_wr_data = '0;
   logic        tf_rd_en = 1'b0;
   logic [2:0]  tf_rd_addr = '0;
   logic        ctl_wr_en = 1'b0;
   logic        ctl_wr_hob = 1'b0;
   logic        ctl_wr_srst = 1'b0;
   logic        ctl_wr_nien = 1'b0;
   logic        irq_raise = 1'b0;
   logic [7:0]  tf_rd_data, alt_status, cmd_code;
   logic        irq, cmd_strobe, cmd_dev;
   logic [15:0] cmd_feature;
   logic [7:0]  rd2_data, alt2_status, code2;
   logic        irq2, strobe2, dev2;
   logic [15:0] feat2;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ata_taskfile_regs #(.DEV_PRESENT(2'b11), .DEV_PACKET(2'b10), .SRST_DELAY(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .tf_wr_en(tf_wr_en), .tf_wr_addr(tf_wr_addr),
      .tf_wr_data(tf_wr_data), .tf_rd_en(tf_rd_en), .tf_rd_addr(tf_rd_addr),
      .tf_rd_data(tf_rd_data), .ctl_wr_en(ctl_wr_en), .ctl_wr_hob(ctl_wr_hob),
      .ctl_wr_srst(ctl_wr_srst), .ctl_wr_nien(ctl_wr_nien), .alt_status(alt_status),
      .irq_raise(irq_raise), .irq(irq), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
      .cmd_dev(cmd_dev), .cmd_feature(cmd_feature));

   // second copy with device 1 absent, driven by the same bus
   ata_taskfile_regs #(.DEV_PRESENT(2'b01), .DEV_PACKET(2'b10), .SRST_DELAY(3)) dut_abs_i (
      .clk(clk), .rst_n(rst_n), .tf_wr_en(tf_wr_en), .tf_wr_addr(tf_wr_addr),
      .tf_wr_data(tf_wr_data), .tf_rd_en(tf_rd_en), .tf_rd_addr(tf_rd_addr),
      .tf_rd_data(rd2_data), .ctl_wr_en(ctl_wr_en), .ctl_wr_hob(ctl_wr_hob),
      .ctl_wr_srst(ctl_wr_srst), .ctl_wr_nien(ctl_wr_nien), .alt_status(alt2_status),
      .irq_raise(irq_raise), .irq(irq2), .cmd_strobe(strobe2), .cmd_code(code2),
      .cmd_dev(dev2), .cmd_feature(feat2));

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tf_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      tf_wr_en = 1'b1; tf_wr_addr = a; tf_wr_data = d;
      @(negedge clk);
      tf_wr_en = 1'b0;
   endtask

   task automatic ctl_write(input logic hob, input logic srst, input logic nien);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_hob = hob; ctl_wr_srst = srst; ctl_wr_nien = nien;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string req);
      tf_rd_addr = a;
      #1;
      check({8'h00, tf_rd_data}, {8'h00, exp}, req);
   endtask

   task automatic pulse_raise();
      @(negedge clk);
      irq_raise = 1'b1;
      @(negedge clk);
      irq_raise = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 hardware reset state
      peek(3'd1, 8'h01, "R12 error");
      peek(3'd2, 8'h01, "R12 count");
      peek(3'd3, 8'h01, "R12 lba low");
      peek(3'd4, 8'h00, "R12 lba mid");
      peek(3'd5, 8'h00, "R12 lba high");
      peek(3'd6, 8'hA0, "R12 device/head");
      peek(3'd7, 8'h50, "R12 status");
      check({15'd0, irq}, 16'd0, "R12 irq");
      check({15'd0, cmd_strobe}, 16'd0, "R12 strobe");
      check({8'h00, alt_status}, 16'h0050, "R12 alt status");

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].kind)
            2'd0: tf_write(VECS[i].addr, VECS[i].data);
            2'd2: ctl_write(VECS[i].data[7], VECS[i].data[2], VECS[i].data[1]);
            default: peek(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
         endcase
      end

      // R7 masked raise has no effect, unmasked raise sets the line
      ctl_write(1'b0, 1'b0, 1'b1);
      pulse_raise();
      check({15'd0, irq}, 16'd0, "R7 masked");
      ctl_write(1'b0, 1'b0, 1'b0);
      pulse_raise();
      check({15'd0, irq}, 16'd1, "R7 unmasked");

      // R10 alternate status leaves the line, status read clears it
      @(negedge clk);
      check({8'h00, alt_status}, 16'h0050, "R10 alt value");
      check({15'd0, irq}, 16'd1, "R10 alt no clear");
      tf_rd_addr = 3'd7; tf_rd_en = 1'b1;
      #1;
      check({8'h00, tf_rd_data}, 16'h0050, "R10 status value");
      @(negedge clk);
      tf_rd_en = 1'b0;
      check({15'd0, irq}, 16'd0, "R10 status read clears");

      // R6 command issue on device 1 with feature shadow
      tf_write(3'd6, 8'h10);
      tf_write(3'd1, 8'h5A);
      tf_write(3'd1, 8'hA5);
      pulse_raise();
      check({15'd0, irq}, 16'd1, "R6 irq before");
      @(negedge clk);
      tf_wr_en = 1'b1; tf_wr_addr = 3'd7; tf_wr_data = 8'hEC;
      @(negedge clk);
      tf_wr_en = 1'b0;
      check({15'd0, cmd_strobe}, 16'd1, "R6 strobe");
      check({8'h00, cmd_code}, 16'h00EC, "R6 code");
      check({15'd0, cmd_dev}, 16'd1, "R6 device");
      check(cmd_feature, 16'h5AA5, "R6 feature");
      check({15'd0, irq}, 16'd0, "R6 irq dropped");
      @(negedge clk);
      check({15'd0, cmd_strobe}, 16'd0, "R6 one cycle");

      // R9 rising and repeated reset bit start nothing (device 1, packet, idle 00)
      ctl_write(1'b0, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check({8'h00, alt_status}, 16'h0000, "R9 rising");
      ctl_write(1'b0, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check({8'h00, alt_status}, 16'h0000, "R9 repeated");

      // R8 falling reset bit: busy, then signature after the delay
      tf_write(3'd2, 8'h77);
      tf_write(3'd2, 8'h78);
      ctl_write(1'b0, 1'b0, 1'b0);
      check({8'h00, alt_status}, 16'h0080, "R8 busy at edge");
      repeat (2) @(negedge clk);
      check({8'h00, alt_status}, 16'h0080, "R8 busy held");
      @(negedge clk);
      check({8'h00, alt_status}, 16'h0050, "R8 idle after delay");
      peek(3'd6, 8'hA0, "R8 device/head");
      peek(3'd2, 8'h01, "R8 count");
      peek(3'd3, 8'h01, "R8 lba low");
      ctl_write(1'b1, 1'b0, 1'b0);
      peek(3'd2, 8'h00, "R8 count shadow");
      ctl_write(1'b0, 1'b0, 1'b0);
      tf_write(3'd6, 8'h10);
      peek(3'd7, 8'h00, "R8 packet status");

      // R11 absent device reads zero, present data port floats high
      tf_rd_addr = 3'd7;
      #1;
      check({8'h00, rd2_data}, 16'h0000, "R11 absent status");
      check({8'h00, alt2_status}, 16'h0000, "R11 absent alt");
      tf_rd_addr = 3'd0;
      #1;
      check({8'h00, rd2_data}, 16'h0000, "R11 absent data");
      check({8'h00, tf_rd_data}, 16'h00FF, "R11 present data");
      tf_write(3'd6, 8'h00);
      tf_rd_addr = 3'd7;
      #1;
      check({8'h00, rd2_data}, 16'h0050, "R11 present device 0");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule